// File: doc/BRIEF.md
# Strobed Input Port Handshake

This block provides the handshake for one 8-bit parallel port that is set up as a strobed input. The peripheral places a byte on the port pins and pulses an active-low strobe. The block captures that byte into a holding latch and raises a buffer-full flag. It can also raise an active-high interrupt request so the CPU knows a byte is waiting. The CPU then reads the port through an active-low read strobe, which clears the interrupt and then the full flag.

The strobe and read inputs arrive asynchronously. Each passes through a synchronizer, and the block acts only on edges seen in the synchronized copies. The interrupt enable is a single bit. It is written with the same single-bit set/reset command words that control port C. The block drives the two port C status lines that belong to its port. A parameter selects whether it serves the first port (port A) or the second port (port B). Bus decoding is outside the block: the CPU side arrives as an already-decoded read strobe and a one-cycle command-write pulse.

Top module: `strobe_in_port`

## Requirements
- R1: While reset is asserted and after it is released, `readData` is 0, `bufFull` is 0, `intReq` is 0 and the interrupt enable is 0.
- R2: When the synchronized `strobeN` falls, `portIn` is captured into `readData` and `bufFull` becomes 1. Both happen no later than SYNC_STAGES+1 clock edges after `strobeN` goes low.
- R3: `readData` changes only when a strobe falling edge is detected. A CPU read leaves it unchanged.
- R4: `bufFull` clears on the rising edge of `readN` (the end of the read). It stays at 1 while `readN` is low.
- R5: `intReq` clears on the falling edge of `readN` (the start of the read).
- R6: `intReq` rises only on a strobe rising edge, and only when `bufFull` is 1 and the interrupt enable is 1. With the enable at 0, a complete strobe pulse leaves `intReq` at 0.
- R7: A command with `cmdWrite` high, `cmdData[7]`=0 and `cmdData[3:1]` equal to the port's enable bit index writes `cmdData[0]` into the interrupt enable. The index is 4 for port A and 2 for port B. Writing 0 also drops a pending `intReq`. `intReq` is never 1 while the enable is 0. Commands that carry another bit index, or that have `cmdData[7]`=1, leave the enable unchanged.
- R8: A second strobe that arrives while `bufFull` is 1 overwrites the latched byte, and `bufFull` stays 1.
- R9: For port A (PORT_SEL=0), `pcLines[5]` is the full flag and `pcLines[3]` is the interrupt request, with `pcDriveEn`=8'h28. For port B, `pcLines[1]` is the full flag and `pcLines[0]` is the interrupt request, with `pcDriveEn`=8'h03. All other `pcLines` bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| portIn | input | 8 | Data from the peripheral on the port pins |
| strobeN | input | 1 | Active-low peripheral strobe, asynchronous |
| readN | input | 1 | Active-low decoded CPU read of this port, asynchronous |
| cmdWrite | input | 1 | One-cycle pulse: a control word is written |
| cmdData | input | 8 | Control word value |
| readData | output | 8 | Latched input byte |
| bufFull | output | 1 | Input buffer full flag |
| intReq | output | 1 | Active-high interrupt request |
| pcLines | output | 8 | Port C status line values driven by this block |
| pcDriveEn | output | 8 | Mask of the port C bits this block drives |

## Verification
The assertions assume that `portIn` is stable from before the strobe falls until the capture, because the synchronizer delay means the capture happens a few clocks after the edge. They also assume that `strobeN` and `readN` pulses last long enough, and stay apart long enough, for each edge to pass through the synchronizer on its own. The stimulus meets these conditions in three ways: it changes inputs only on falling clock edges, it holds the data for the whole strobe pulse, and it leaves several clocks between every edge of the strobe and read lines.

// File: rtl/sip_pkg.sv
package sip_pkg;
  typedef struct packed {
    logic loadData;
    logic setFull;
    logic clrFull;
    logic setIntr;
    logic clrIntr;
    logic writeInte;
    logic inteVal;
  } sipCtrl_t;
endpackage

// File: rtl/sip_sync_edge.sv
module sip_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic fallPulse,
  output logic risePulse
);
  logic [STAGES-1:0] chain;
  logic prevQ;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[i] <= 1'b1;
        else if (i == 0) chain[i] <= asyncIn;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b1;
    else prevQ <= chain[STAGES-1];
  end

  assign fallPulse = prevQ & ~chain[STAGES-1];
  assign risePulse = ~prevQ & chain[STAGES-1];
endmodule

// File: rtl/sip_ctrl.sv
module sip_ctrl
  import sip_pkg::*;
#(
  parameter int INTE_IDX = 4
) (
  input  logic       strobeFall,
  input  logic       strobeRise,
  input  logic       readFall,
  input  logic       readRise,
  input  logic       cmdWrite,
  input  logic [7:0] cmdData,
  input  logic       fullQ,
  input  logic       inteQ,
  output sipCtrl_t   ctl
);
  localparam logic [2:0] INTE_SEL = 3'(INTE_IDX);

  logic inteHit;
  logic inteDrop;

  always_comb begin
    inteHit  = cmdWrite & ~cmdData[7] & (cmdData[3:1] == INTE_SEL);
    inteDrop = inteHit & ~cmdData[0];
    ctl.loadData  = strobeFall;
    ctl.setFull   = strobeFall;
    ctl.clrFull   = readRise;
    ctl.setIntr   = strobeRise & fullQ & inteQ & ~inteDrop;
    ctl.clrIntr   = readFall | inteDrop;
    ctl.writeInte = inteHit;
    ctl.inteVal   = cmdData[0];
  end
endmodule

// File: rtl/sip_datapath.sv
module sip_datapath
  import sip_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int PC_W     = 8,
  parameter int IBF_IDX  = 5,
  parameter int INTR_IDX = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  sipCtrl_t          ctl,
  input  logic [DATA_W-1:0] portIn,
  output logic [DATA_W-1:0] dataQ,
  output logic              fullQ,
  output logic              intrQ,
  output logic              inteQ,
  output logic [PC_W-1:0]   pcLines,
  output logic [PC_W-1:0]   pcDriveEn
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '0;
      fullQ <= 1'b0;
      intrQ <= 1'b0;
      inteQ <= 1'b0;
    end else begin
      if (ctl.loadData) dataQ <= portIn;
      if (ctl.setFull) fullQ <= 1'b1;
      else if (ctl.clrFull) fullQ <= 1'b0;
      if (ctl.setIntr) intrQ <= 1'b1;
      else if (ctl.clrIntr) intrQ <= 1'b0;
      if (ctl.writeInte) inteQ <= ctl.inteVal;
    end
  end

  generate
    for (genvar i = 0; i < PC_W; i++) begin : g_pc
      if (i == IBF_IDX) begin : g_ibf
        assign pcLines[i]   = fullQ;
        assign pcDriveEn[i] = 1'b1;
      end else if (i == INTR_IDX) begin : g_intr
        assign pcLines[i]   = intrQ;
        assign pcDriveEn[i] = 1'b1;
      end else begin : g_idle
        assign pcLines[i]   = 1'b0;
        assign pcDriveEn[i] = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/strobe_in_port.sv
module strobe_in_port
  import sip_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PORT_SEL    = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] portIn,
  input  logic              strobeN,
  input  logic              readN,
  input  logic              cmdWrite,
  input  logic [7:0]        cmdData,
  output logic [DATA_W-1:0] readData,
  output logic              bufFull,
  output logic              intReq,
  output logic [7:0]        pcLines,
  output logic [7:0]        pcDriveEn
);
  localparam int IBF_IDX  = (PORT_SEL == 0) ? 5 : 1;
  localparam int INTR_IDX = (PORT_SEL == 0) ? 3 : 0;
  localparam int INTE_IDX = (PORT_SEL == 0) ? 4 : 2;

  logic strobeFall, strobeRise, readFall, readRise;
  logic inteState;
  sipCtrl_t ctl;

  sip_sync_edge #(.STAGES(SYNC_STAGES)) u_strobeSync (
    .clk(clk), .rstN(rstN), .asyncIn(strobeN),
    .fallPulse(strobeFall), .risePulse(strobeRise)
  );

  sip_sync_edge #(.STAGES(SYNC_STAGES)) u_readSync (
    .clk(clk), .rstN(rstN), .asyncIn(readN),
    .fallPulse(readFall), .risePulse(readRise)
  );

  sip_ctrl #(.INTE_IDX(INTE_IDX)) u_ctrl (
    .strobeFall(strobeFall), .strobeRise(strobeRise),
    .readFall(readFall), .readRise(readRise),
    .cmdWrite(cmdWrite), .cmdData(cmdData),
    .fullQ(bufFull), .inteQ(inteState), .ctl(ctl)
  );

  sip_datapath #(
    .DATA_W(DATA_W), .PC_W(8), .IBF_IDX(IBF_IDX), .INTR_IDX(INTR_IDX)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .portIn(portIn),
    .dataQ(readData), .fullQ(bufFull), .intrQ(intReq), .inteQ(inteState),
    .pcLines(pcLines), .pcDriveEn(pcDriveEn)
  );
endmodule

// File: rtl/strobe_in_port_chk.sv
module strobe_in_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] portIn,
  input logic              strobeFall,
  input logic              strobeRise,
  input logic              readFall,
  input logic              readRise,
  input logic [DATA_W-1:0] readData,
  input logic              bufFull,
  input logic              intReq,
  input logic              inteState
);
  assert_capture_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobeFall |=> (bufFull && readData == $past(portIn)))
    else $error("capture after strobe fall");

  assert_hold_data_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobeFall |=> $stable(readData))
    else $error("latched data moved without strobe");

  assert_full_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (readRise && !strobeFall) |=> !bufFull)
    else $error("full not cleared at read end");

  assert_intr_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (readFall && !strobeRise) |=> !intReq)
    else $error("interrupt not cleared at read start");

  assert_intr_source_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intReq) |-> $past(strobeRise && bufFull && inteState))
    else $error("interrupt rose without qualified strobe rise");

  assert_intr_needs_enable_R7: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> inteState)
    else $error("interrupt active with enable clear");
endmodule

bind strobe_in_port strobe_in_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .portIn(portIn),
  .strobeFall(strobeFall), .strobeRise(strobeRise),
  .readFall(readFall), .readRise(readRise),
  .readData(readData), .bufFull(bufFull), .intReq(intReq),
  .inteState(inteState)
);

// File: tb/strobe_in_port_bench.sv
module strobe_in_port_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] portIn = 8'h00;
  logic strobeN = 1'b1;
  logic readN = 1'b1;
  logic cmdWrite = 1'b0;
  logic [7:0] cmdData = 8'h00;
  logic [7:0] readData;
  logic bufFull, intReq;
  logic [7:0] pcLines, pcDriveEn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  strobe_in_port u_strobe_in_port (
    .clk(clk), .rstN(rstN), .portIn(portIn), .strobeN(strobeN),
    .readN(readN), .cmdWrite(cmdWrite), .cmdData(cmdData),
    .readData(readData), .bufFull(bufFull), .intReq(intReq),
    .pcLines(pcLines), .pcDriveEn(pcDriveEn)
  );

  // vector: {data[7:0], enable, expected intReq after strobe}
  localparam logic [9:0] VEC [6] = '{
    {8'hA5, 1'b1, 1'b1}, {8'h3C, 1'b0, 1'b0}, {8'hFF, 1'b1, 1'b1},
    {8'h00, 1'b0, 1'b0}, {8'h81, 1'b1, 1'b1}, {8'h5A, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sendCmd(input logic [7:0] val);
    cmdData = val;
    cmdWrite = 1'b1;
    @(negedge clk);
    cmdWrite = 1'b0;
    waitCyc(1);
  endtask

  task automatic strobeLow(input logic [7:0] val);
    portIn = val;
    waitCyc(1);
    strobeN = 1'b0;
    waitCyc(5);
  endtask

  task automatic strobeHigh();
    strobeN = 1'b1;
    waitCyc(5);
  endtask

  function automatic logic [7:0] expPc(input logic f, input logic i);
    return {2'b00, f, 1'b0, i, 3'b000};
  endfunction

  initial begin
    waitCyc(2);
    check("R1 data in reset", 32'(readData), 32'h0);
    check("R1 full in reset", 32'(bufFull), 32'h0);
    rstN = 1'b1;
    waitCyc(2);
    check("R1 intr after reset", 32'(intReq), 32'h0);
    check("R9 drive mask", 32'(pcDriveEn), 32'h28);
    check("R9 lines idle", 32'(pcLines), 32'h0);

    for (int k = 0; k < 6; k++) begin
      sendCmd({4'b0000, 3'd4, VEC[k][1]});
      strobeLow(VEC[k][9:2]);
      check("R2 captured byte", 32'(readData), 32'(VEC[k][9:2]));
      check("R2 full after strobe", 32'(bufFull), 32'h1);
      check("R6 no intr before strobe rise", 32'(intReq), 32'h0);
      strobeHigh();
      check("R6 intr after strobe rise", 32'(intReq), 32'(VEC[k][0]));
      check("R9 status lines", 32'(pcLines), 32'(expPc(1'b1, VEC[k][0])));
      readN = 1'b0;
      waitCyc(5);
      check("R5 intr cleared at read start", 32'(intReq), 32'h0);
      check("R4 full held during read", 32'(bufFull), 32'h1);
      readN = 1'b1;
      waitCyc(5);
      check("R4 full cleared at read end", 32'(bufFull), 32'h0);
      check("R3 data kept after read", 32'(readData), 32'(VEC[k][9:2]));
    end

    // R8: overwrite while full
    sendCmd(8'h08);
    strobeLow(8'h11);
    strobeHigh();
    strobeLow(8'h22);
    check("R8 overwritten byte", 32'(readData), 32'h22);
    check("R8 full stays", 32'(bufFull), 32'h1);
    strobeHigh();

    // R7: disabling drops pending interrupt; enable at 1 first
    sendCmd(8'h09);
    readN = 1'b0; waitCyc(5); readN = 1'b1; waitCyc(5);
    strobeLow(8'h33);
    strobeHigh();
    check("R7 intr pending", 32'(intReq), 32'h1);
    sendCmd(8'h08);
    check("R7 disable drops intr", 32'(intReq), 32'h0);
    check("R7 full unaffected", 32'(bufFull), 32'h1);
    readN = 1'b0; waitCyc(5); readN = 1'b1; waitCyc(5);

    // R7: other bit index and mode word leave enable at 0
    sendCmd(8'h05);
    sendCmd(8'h89);
    strobeLow(8'h44);
    strobeHigh();
    check("R7 ignored commands keep enable off", 32'(intReq), 32'h0);
    check("R3 data from last strobe", 32'(readData), 32'h44);

    // R1: reset mid-operation
    rstN = 1'b0;
    waitCyc(2);
    check("R1 data cleared by reset", 32'(readData), 32'h0);
    check("R1 full cleared by reset", 32'(bufFull), 32'h0);
    rstN = 1'b1;
    waitCyc(2);
    strobeLow(8'h55);
    strobeHigh();
    check("R1 enable cleared by reset", 32'(intReq), 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule